// File: doc/BRIEF.md
# Sensor Row Zero-Bias Corrector

The corrector accepts raw bytes from an image sensor row by row over a valid/ready stream. Each row ends with a pair of light-shielded reference cells whose readings show the dark-level error of that row. After a full row has arrived, the block averages the two reference readings into a row offset. It then subtracts the offset from each active pixel and writes the corrected pixels into an internal frame buffer.

A host starts a frame with a one-cycle start pulse, waits for the done flag, and then fetches the corrected image with single-cycle reads on a 16-bit address / 8-bit data bus. The buffer sits in the device part of the address space. Reads anywhere else get zero from this block.

Top module: `zbias_row_corrector`

## Requirements
- R1: Each row is taken as 66 accepted bytes (valid and ready both high at a rising edge): accepted bytes 0..63 are the active pixels of columns 0..63, and bytes 64 and 65 are the two reference cells. pix_ready_o is high only while a row is being collected, never while idle, and reference cells are never written to the image.
- R2: The row offset is (m0 + m1) / 2, where both cells are signed 8-bit values and the division truncates toward zero (for example -3 gives -1 and -1 gives 0).
- R3: Each corrected pixel is (pixel - offset) modulo 256 in 8-bit two's complement. There is no saturation.
- R4: The corrected pixel of row r, column c is read at bus address 0x4000 + r*64 + c.
- R5: When bus_rd_i is high at a rising edge, bus_rdata_o holds the addressed byte for exactly the following cycle. In every other cycle it is zero.
- R6: A read at an address whose upper byte is zero (RAM space), or anywhere outside 0x4000..0x4FFF, returns zero.
- R7: A start pulse while idle begins a 64-row frame and clears done_o. done_o goes high one cycle after the last pixel of row 63 is written, and it stays high until the next start.
- R8: A start pulse while busy_o is high has no effect: the frame goes on from the same row and column.
- R9: While reset is asserted, busy_o, done_o, pix_ready_o and bus_rdata_o are all zero.
- R10: Each row's offset comes only from that row's own reference cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame (only acted on while idle) |
| pix_valid_i | input | 1 | Sensor byte valid |
| pix_data_i | input | 8 | Sensor byte |
| pix_ready_o | output | 1 | Block ready to accept a sensor byte |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Last frame finished |
| bus_addr_i | input | 16 | Host read address |
| bus_rd_i | input | 1 | Host read strobe, one cycle |
| bus_rdata_o | output | 8 | Read data, valid the cycle after the strobe |

## Verification
The bench drives reference pairs that expose each part of the offset arithmetic. A pair summing to -255 or to an odd negative value catches a shift used in place of a truncating division, which would be off by one toward minus infinity. Extreme pixels against extreme offsets catch saturation or a widened subtract, which would clamp instead of wrapping. Reads at both edges of the buffer window and in RAM space catch a loose address decode, which would return image bytes at the wrong places. A start pulse in the middle of a frame, together with a done flag checked against the exact cycle count, catches a controller that restarts or finishes early.

// File: rtl/zb_pkg.sv
package zb_pkg;
  typedef enum logic [2:0] {
    ZB_IDLE,
    ZB_GET_ROW,
    ZB_CALC,
    ZB_FIX,
    ZB_NEXT
  } zb_state_e;
endpackage

// File: rtl/zb_ctrl.sv
module zb_ctrl
  import zb_pkg::*;
#(
  parameter int unsigned ROWS  = 64,
  parameter int unsigned COLS  = 64,
  parameter int unsigned MASKS = 2,
  localparam int unsigned RW = $clog2(ROWS),
  localparam int unsigned CW = $clog2(COLS + MASKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          pix_valid_i,
  output logic          pix_ready_o,
  output logic          cap_we_o,
  output logic          calc_en_o,
  output logic          fix_we_o,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LAST_IN  = CW'(COLS + MASKS - 1);
  localparam logic [CW-1:0] LAST_PIX = CW'(COLS - 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  zb_state_e     state_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ZB_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ZB_IDLE: begin
          if (start_i) begin
            state_q <= ZB_GET_ROW;
            row_q   <= '0;
            col_q   <= '0;
            done_q  <= 1'b0;
          end
        end
        ZB_GET_ROW: begin
          if (pix_valid_i) begin
            if (col_q == LAST_IN) begin
              state_q <= ZB_CALC;
              col_q   <= '0;
            end else begin
              col_q <= col_q + 1'b1;
            end
          end
        end
        ZB_CALC: state_q <= ZB_FIX;
        ZB_FIX: begin
          if (col_q == LAST_PIX) begin
            state_q <= ZB_NEXT;
            col_q   <= '0;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        ZB_NEXT: begin
          if (row_q == LAST_ROW) begin
            state_q <= ZB_IDLE;
            done_q  <= 1'b1;
          end else begin
            row_q   <= row_q + 1'b1;
            state_q <= ZB_GET_ROW;
          end
        end
        default: state_q <= ZB_IDLE;
      endcase
    end
  end

  assign pix_ready_o = (state_q == ZB_GET_ROW);
  assign cap_we_o    = pix_ready_o && pix_valid_i;
  assign calc_en_o   = (state_q == ZB_CALC);
  assign fix_we_o    = (state_q == ZB_FIX);
  assign row_o       = row_q;
  assign col_o       = col_q;
  assign busy_o      = (state_q != ZB_IDLE);
  assign done_o      = done_q;
endmodule

// File: rtl/zb_row_buf.sv
module zb_row_buf #(
  parameter int unsigned COLS  = 64,
  parameter int unsigned MASKS = 2,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW = $clog2(COLS + MASKS),
  localparam int unsigned PW = $clog2(COLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          calc_en_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic [DW-1:0] corr_o
);
  localparam int unsigned SW = DW + $clog2(MASKS) + 1;

  logic [DW-1:0] pix_q  [COLS];
  logic [DW-1:0] mask_q [MASKS];
  logic [DW-1:0] bias_q;
  logic signed [SW-1:0] sum, quo;
  logic unused_quo_hi;

  always_ff @(posedge clk_i) begin
    if (wr_en_i && (wr_idx_i < CW'(COLS))) pix_q[wr_idx_i[PW-1:0]] <= wr_data_i;
  end

  for (genvar m = 0; m < MASKS; m++) begin : g_mask
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_idx_i == CW'(COLS + m))) mask_q[m] <= wr_data_i;
    end
  end

  // signed mean, truncated toward zero
  always_comb begin
    sum = '0;
    for (int m = 0; m < MASKS; m++) sum = sum + SW'($signed(mask_q[m]));
    quo = sum / $signed(SW'(MASKS));
  end
  assign unused_quo_hi = ^quo[SW-1:DW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bias_q <= '0;
    else if (calc_en_i) bias_q <= quo[DW-1:0];
  end

  assign corr_o = pix_q[rd_idx_i] - bias_q;
endmodule

// File: rtl/zb_frame_mem.sv
module zb_frame_mem #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rd_q <= mem_q[raddr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/zb_bus_port.sv
module zb_bus_port #(
  parameter int unsigned BASE  = 32'h4000,
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [15:0]   addr_i,
  input  logic          rd_i,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_idx_o,
  input  logic [DW-1:0] mem_data_i,
  output logic [DW-1:0] rdata_o
);
  localparam logic [16:0] LO = 17'(BASE);
  localparam logic [16:0] HI = 17'(BASE + DEPTH);

  logic in_win, hit_q;

  // window sits above 0x00FF, so RAM space never decodes here
  assign in_win    = ({1'b0, addr_i} >= LO) && ({1'b0, addr_i} < HI);
  assign mem_re_o  = rd_i && in_win;
  assign mem_idx_o = AW'(addr_i - 16'(BASE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= mem_re_o;
  end

  assign rdata_o = hit_q ? mem_data_i : '0;
endmodule

// File: rtl/zbias_row_corrector.sv
module zbias_row_corrector #(
  parameter int unsigned ROWS  = 64,
  parameter int unsigned COLS  = 64,
  parameter int unsigned MASKS = 2,
  parameter int unsigned BASE  = 32'h4000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        pix_valid_i,
  input  logic [7:0]  pix_data_i,
  output logic        pix_ready_o,
  output logic        busy_o,
  output logic        done_o,
  input  logic [15:0] bus_addr_i,
  input  logic        bus_rd_i,
  output logic [7:0]  bus_rdata_o
);
  localparam int unsigned DW    = 8;
  localparam int unsigned DEPTH = ROWS * COLS;
  localparam int unsigned FAW   = $clog2(DEPTH);
  localparam int unsigned RW    = $clog2(ROWS);
  localparam int unsigned CW    = $clog2(COLS + MASKS);
  localparam int unsigned PW    = $clog2(COLS);

  logic          cap_we, calc_en, fix_we;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [DW-1:0] corr;
  logic [FAW-1:0] waddr;
  logic          mem_re;
  logic [FAW-1:0] mem_idx;
  logic [DW-1:0] mem_data;

  zb_ctrl #(.ROWS(ROWS), .COLS(COLS), .MASKS(MASKS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .pix_valid_i (pix_valid_i),
    .pix_ready_o (pix_ready_o),
    .cap_we_o    (cap_we),
    .calc_en_o   (calc_en),
    .fix_we_o    (fix_we),
    .row_o       (row),
    .col_o       (col),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  zb_row_buf #(.COLS(COLS), .MASKS(MASKS), .DW(DW)) u_row (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cap_we),
    .wr_idx_i  (col),
    .wr_data_i (pix_data_i),
    .calc_en_i (calc_en),
    .rd_idx_i  (col[PW-1:0]),
    .corr_o    (corr)
  );

  assign waddr = FAW'(row) * FAW'(COLS) + FAW'(col);

  zb_frame_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (fix_we),
    .waddr_i (waddr),
    .wdata_i (corr),
    .re_i    (mem_re),
    .raddr_i (mem_idx),
    .rdata_o (mem_data)
  );

  zb_bus_port #(.BASE(BASE), .DEPTH(DEPTH), .DW(DW)) u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (bus_addr_i),
    .rd_i       (bus_rd_i),
    .mem_re_o   (mem_re),
    .mem_idx_o  (mem_idx),
    .mem_data_i (mem_data),
    .rdata_o    (bus_rdata_o)
  );
endmodule

// File: rtl/zb_checker.sv
module zb_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        pix_ready_o,
  input logic        busy_o,
  input logic        done_o,
  input logic [15:0] bus_addr_i,
  input logic        bus_rd_i,
  input logic [7:0]  bus_rdata_o
);
  p_ready_only_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ready_o |-> busy_o);

  p_rdata_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> bus_rdata_o == 8'h00);

  p_ram_space_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i[15:8] == 8'h00) |=> bus_rdata_o == 8'h00);

  p_done_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  p_done_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> (!done_o && busy_o));

  p_done_not_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  p_busy_needs_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind zbias_row_corrector zb_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .pix_ready_o (pix_ready_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .bus_addr_i  (bus_addr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_rdata_o (bus_rdata_o)
);

// File: tb/sim_zbias_row_corrector.sv
module sim_zbias_row_corrector;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 64;
  localparam int COLS = 64;
  localparam int BASE = 32'h4000;
  localparam int WDOG = 200000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        pix_valid_i = 1'b0;
  logic [7:0]  pix_data_i = 8'h00;
  logic        pix_ready_o, busy_o, done_o;
  logic [15:0] bus_addr_i = 16'h0000;
  logic        bus_rd_i = 1'b0;
  logic [7:0]  bus_rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] exp_img [ROWS][COLS];

  zbias_row_corrector u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i), .pix_ready_o(pix_ready_o),
    .busy_o(busy_o), .done_o(done_o),
    .bus_addr_i(bus_addr_i), .bus_rd_i(bus_rd_i), .bus_rdata_o(bus_rdata_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] offset_of(logic [7:0] a, logic [7:0] b);
    int s = int'($signed(a)) + int'($signed(b));
    int q = s / 2;
    return q[7:0];
  endfunction

  function automatic logic [7:0] fix_of(logic [7:0] p, logic [7:0] off);
    int d = int'($signed(p)) - int'($signed(off));
    return d[7:0];
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    pix_valid_i = 1'b1;
    pix_data_i  = b;
    while (!pix_ready_o) @(negedge clk);
    @(negedge clk);
    pix_valid_i = 1'b0;
    if (($urandom % 4) == 0) repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic bus_read(logic [15:0] a, output logic [7:0] d);
    bus_addr_i = a;
    bus_rd_i   = 1'b1;
    @(negedge clk);
    bus_rd_i   = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // frame 0: directed reference pairs on early rows; frame 1: directed on last row
  task automatic send_row(int frame, int r);
    logic [7:0] px [COLS];
    logic [7:0] m0, m1, off;
    for (int c = 0; c < COLS; c++) px[c] = 8'($urandom);
    m0 = 8'($urandom % 24);
    m1 = 8'($urandom % 24);
    if (frame == 0) begin
      case (r)
        0: begin m0 = 8'h80; m1 = 8'h81; px[0] = 8'h80; end
        1: begin m0 = 8'h7f; m1 = 8'h7f; px[0] = 8'h80; end
        2: begin m0 = 8'hff; m1 = 8'h00; end
        3: begin m0 = 8'h01; m1 = 8'h00; end
        4: begin m0 = 8'hfd; m1 = 8'h00; end
        5: begin m0 = 8'h7f; m1 = 8'h7e; px[COLS-1] = 8'h7f; end
        default: ;
      endcase
    end else if (r == ROWS-1) begin
      m0 = 8'h80; m1 = 8'h80; px[COLS-1] = 8'h7f;
    end
    off = offset_of(m0, m1);
    for (int c = 0; c < COLS; c++) exp_img[r][c] = fix_of(px[c], off);
    for (int c = 0; c < COLS; c++) send_byte(px[c]);
    send_byte(m0);
    send_byte(m1);
  endtask

  task automatic run_frame(int frame);
    pulse_start();
    chk("R7 busy after start", {7'b0, busy_o}, 8'h01);
    chk("R7 done cleared by start", {7'b0, done_o}, 8'h00);
    for (int r = 0; r < ROWS; r++) begin
      if (r == 10) begin
        pulse_start();
        chk("R8 start while busy keeps busy", {7'b0, busy_o}, 8'h01);
      end
      send_row(frame, r);
    end
    repeat (64) @(negedge clk);
    chk("R7 done not early", {7'b0, done_o}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R7 done after last row", {7'b0, done_o}, 8'h01);
    chk("R1 ready low when idle", {7'b0, pix_ready_o}, 8'h00);
  endtask

  task automatic read_frame();
    logic [7:0] d;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        bus_read(16'(BASE + r*COLS + c), d);
        chk("R2 R3 R4 R10 corrected pixel", d, exp_img[r][c]);
      end
  endtask

  initial begin : wdog
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R9 busy in reset", {7'b0, busy_o}, 8'h00);
    chk("R9 done in reset", {7'b0, done_o}, 8'h00);
    chk("R9 ready in reset", {7'b0, pix_ready_o}, 8'h00);
    chk("R9 rdata in reset", bus_rdata_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 ready low before start", {7'b0, pix_ready_o}, 8'h00);

    run_frame(0);
    chk("R2 R3 row0 -128 minus -127", exp_img[0][0], 8'hff);
    chk("R3 row1 wrap -128 minus 127", exp_img[1][0], 8'h01);
    read_frame();

    // R5: data only in the cycle after the strobe
    bus_read(16'(BASE + COLS), d);
    chk("R5 data one cycle after strobe", d, 8'h01);
    @(negedge clk);
    chk("R5 data gone next cycle", bus_rdata_o, 8'h00);

    // R6: outside the window
    bus_read(16'(BASE - 1), d);      chk("R6 below window", d, 8'h00);
    bus_read(16'(BASE + ROWS*COLS), d); chk("R6 above window", d, 8'h00);
    bus_read(16'h0000, d);           chk("R6 RAM space low", d, 8'h00);
    bus_read(16'h00ff, d);           chk("R6 RAM space high", d, 8'h00);
    bus_read(16'(BASE), d);          chk("R4 first word", d, exp_img[0][0]);

    run_frame(1);
    chk("R3 row63 127 minus -128 wraps", exp_img[ROWS-1][COLS-1], 8'hff);
    read_frame();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule